// File: doc/BRIEF.md
# Integer Execution Unit with Set-on-Compare

This block is the purely combinational integer datapath of a small load/store processor core. Each evaluation takes a first operand, a second operand and a 4-bit operation code. It returns one 32-bit value for one of the following:

- addition or subtraction;
- a bitwise AND, OR or XOR;
- a left shift, a logical right shift or an arithmetic right shift;
- one of six signed relational tests.

A relational test does not set condition flags. It writes 1 or 0 as a complete 32-bit word, so a later conditional branch can test that word against zero.

The second operand comes either from a register value or from a 16-bit immediate, as chosen by a decode input. The operation code alone decides how the immediate is widened. The logical operations zero-extend it. Every other operation sign-extends it. Because of this, adding an immediate to a zero first operand loads a constant. The block also reports whether the first operand is zero, which the branch logic uses. It holds no state and has no clock.

Top module: `int_exec_unit`

## Requirements
- R1: Code 0 (add) returns the sum of the first operand and the selected second operand, modulo 2^32, with no overflow indication.
- R2: Code 1 (subtract) returns the first operand minus the selected second operand, modulo 2^32.
- R3: Codes 2, 3 and 4 return the bitwise AND, OR and XOR of the first operand and the register second operand.
- R4: When `use_imm` is 1 and the code is not 2, 3 or 4, the second operand is the immediate with bit 15 copied into bits 31 to 16.
- R5: When `use_imm` is 1 and the code is 2, 3 or 4, the second operand is the immediate with bits 31 to 16 cleared.
- R6: The shift codes take the shift amount from bits 4 to 0 of the second operand. Code 5 shifts left with zero fill. Code 6 shifts right with zero fill. Code 7 shifts right and fills with bit 31 of the first operand.
- R7: Codes 8 to 13 compare the two operands as signed two's-complement values. The relations are less (8), greater (9), less-or-equal (10), greater-or-equal (11), equal (12) and not-equal (13). The result is 32'd1 when the relation holds and 32'd0 otherwise.
- R8: Each code from 0 to 15 selects exactly the operation assigned to it in R1 to R7 and R9.
- R9: Codes 14 and 15 return 32'd0.
- R10: Code 0 with a zero first operand and `use_imm` = 1 returns the sign-extended immediate.
- R11: `a_is_zero` is 1 exactly when all 32 bits of the first operand are 0, whatever the operation.
- R12: When `use_imm` is 0, `imm16` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b_reg | input | 32 | Register form of the second operand |
| imm16 | input | 16 | Immediate form of the second operand |
| use_imm | input | 1 | 1 selects the widened immediate as the second operand |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Destination value |
| a_is_zero | output | 1 | High when the first operand is zero |

## Verification
Operand widening and the relational test act in the same evaluation whenever a compare runs in immediate form. The sign copied from bit 15 then decides the outcome. The bench provokes this with immediates of 0x8000 and 0xFFFF compared against small negative and positive first operands. It also mixes random immediates into all six relations, and judges each result against a model that widens the immediate and compares with `$signed` independently of the design. The zero test and the load-constant path also coincide on add with a zero first operand. These cases are checked together.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SLL = 4'd5,
    OP_SRL = 4'd6,
    OP_SRA = 4'd7,
    OP_SLT = 4'd8,
    OP_SGT = 4'd9,
    OP_SLE = 4'd10,
    OP_SGE = 4'd11,
    OP_SEQ = 4'd12,
    OP_SNE = 4'd13,
    OP_RS0 = 4'd14,
    OP_RS1 = 4'd15
  } alu_op_e;

  function automatic logic op_is_logical(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_compare(alu_op_e op);
    return (op >= OP_SLT) && (op <= OP_SNE);
  endfunction

  // Signed less-than from a subtraction: the sign of the difference,
  // corrected when the subtraction overflowed.
  function automatic logic signed_less(logic a_msb, logic b_msb, logic d_msb);
    logic ovf;
    ovf = (a_msb ^ b_msb) & (d_msb ^ a_msb);
    return d_msb ^ ovf;
  endfunction

  // Select the truth of a relation from less and equal.
  function automatic logic relation_hit(alu_op_e op, logic lt, logic eq);
    logic hit;
    case (op)
      OP_SLT:  hit = lt;
      OP_SGT:  hit = !lt && !eq;
      OP_SLE:  hit = lt || eq;
      OP_SGE:  hit = !lt;
      OP_SEQ:  hit = eq;
      OP_SNE:  hit = !eq;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] op_b_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              zext,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [EXT_W-1:0]  ext_bits;
  logic [DATA_W-1:0] imm_wide;

  assign ext_bits = zext ? '0 : {EXT_W{imm[IMM_W-1]}};
  assign imm_wide = {ext_bits, imm};
  assign opnd_b   = use_imm ? imm_wide : op_b_reg;

  always_comb begin
    if (use_imm && !zext) begin
      assert_sext_R4: assert (opnd_b[DATA_W-1] == imm[IMM_W-1])
        else $error("sign extension lost");
    end
    if (use_imm && zext) begin
      assert_zext_R5: assert (opnd_b < (DATA_W'(1) << IMM_W))
        else $error("zero extension lost");
    end
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic              cmp_hit
);
  localparam int MSB = DATA_W - 1;

  logic lt_w;
  logic eq_w;

  assign sum     = a + b;
  assign diff    = a + ~b + DATA_W'(1);
  assign eq_w    = (a == b);
  assign lt_w    = signed_less(a[MSB], b[MSB], diff[MSB]);
  assign cmp_hit = relation_hit(op, lt_w, eq_w);

  always_comb begin
    assert_lt_excl_eq_R7: assert (!(lt_w && eq_w))
      else $error("less and equal together");
    assert_eq_diff_R2: assert (eq_w == (diff == '0))
      else $error("equality and difference disagree");
  end
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res
);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int MSB     = DATA_W - 1;

  logic [SHAMT_W-1:0] shamt;
  logic [DATA_W-1:0]  sll_w, srl_w, sra_w;

  assign shamt = b[SHAMT_W-1:0];
  assign sll_w = a << shamt;
  assign srl_w = a >> shamt;
  assign sra_w = DATA_W'($signed(a) >>> shamt);

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLL:  res = sll_w;
      OP_SRL:  res = srl_w;
      OP_SRA:  res = sra_w;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (shamt != '0) begin
      assert_srl_fill_R6: assert (!srl_w[MSB])
        else $error("logical right shift filled with one");
      assert_sll_fill_R6: assert (!sll_w[0])
        else $error("left shift filled with one");
    end
    assert_sra_sign_R6: assert (sra_w[MSB] == a[MSB])
      else $error("arithmetic shift lost sign");
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b_reg,
  input  logic [IMM_W-1:0]  imm16,
  input  logic              use_imm,
  input  logic [3:0]        op_sel,
  output logic [DATA_W-1:0] result,
  output logic              a_is_zero
);
  alu_op_e           op_e;
  logic              zext_w;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum_w, diff_w, ls_w;
  logic              cmp_hit_w;

  assign op_e      = alu_op_e'(op_sel);
  assign zext_w    = op_is_logical(op_e);
  assign a_is_zero = (op_a == '0);

  alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op_b_reg (op_b_reg),
    .imm      (imm16),
    .use_imm  (use_imm),
    .zext     (zext_w),
    .opnd_b   (opnd_b)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a       (op_a),
    .b       (opnd_b),
    .op      (op_e),
    .sum     (sum_w),
    .diff    (diff_w),
    .cmp_hit (cmp_hit_w)
  );

  alu_logic_shift #(.DATA_W(DATA_W)) u_ls (
    .a   (op_a),
    .b   (opnd_b),
    .op  (op_e),
    .res (ls_w)
  );

  always_comb begin
    if (op_e == OP_ADD) begin
      result = sum_w;
    end else if (op_e == OP_SUB) begin
      result = diff_w;
    end else if (op_is_compare(op_e)) begin
      result = {{(DATA_W-1){1'b0}}, cmp_hit_w};
    end else begin
      result = ls_w;
    end
  end

  always_comb begin
    if (op_e == OP_ADD && a_is_zero) begin
      assert_ldconst_R10: assert (result == opnd_b)
        else $error("load constant path broken");
    end
    if (op_e == OP_SUB && a_is_zero) begin
      assert_negate_R2: assert (result + opnd_b == '0)
        else $error("subtract from zero not a negation");
    end
    if (op_is_compare(op_e)) begin
      assert_cmp_word_R7: assert ($countones(result) <= 1 && result[DATA_W-1:1] == '0)
        else $error("compare result not 0 or 1");
    end
  end
endmodule

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b_reg = '0;
  logic [15:0] imm16 = '0;
  logic        use_imm = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] result;
  logic        a_is_zero;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_unit u_dut (
    .op_a(op_a), .op_b_reg(op_b_reg), .imm16(imm16), .use_imm(use_imm),
    .op_sel(op_sel), .result(result), .a_is_zero(a_is_zero)
  );

  function automatic logic [31:0] model(logic [3:0] op, logic [31:0] a,
                                        logic [31:0] br, logic [15:0] im, logic ui);
    logic [31:0] b;
    logic signed [31:0] sa, sb;
    if (!ui) b = br;
    else if (op == 4'd2 || op == 4'd3 || op == 4'd4) b = {16'h0000, im};
    else b = {{16{im[15]}}, im};
    sa = a; sb = b;
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return a << b[4:0];
      4'd6:  return a >> b[4:0];
      4'd7:  return sa >>> b[4:0];
      4'd8:  return {31'b0, sa <  sb};
      4'd9:  return {31'b0, sa >  sb};
      4'd10: return {31'b0, sa <= sb};
      4'd11: return {31'b0, sa >= sb};
      4'd12: return {31'b0, sa == sb};
      4'd13: return {31'b0, sa != sb};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] op, logic ui);
    if (op == 4'd0) return "R1";
    if (op == 4'd1) return "R2";
    if (op <= 4'd4) return ui ? "R5" : "R3";
    if (op <= 4'd7) return "R6";
    if (op <= 4'd13) return ui ? "R4" : "R7";
    return "R9";
  endfunction

  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] br,
                       logic [15:0] im, logic ui);
    @(negedge clk);
    op_sel = op; op_a = a; op_b_reg = br; imm16 = im; use_imm = ui;
    #1;
  endtask

  task automatic check(string req, logic [3:0] op, logic [31:0] a,
                       logic [31:0] br, logic [15:0] im, logic ui);
    logic [31:0] exp;
    drive(op, a, br, im, ui);
    exp = model(op, a, br, im, ui);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b: result %h expected %h",
               req, op, a, br, im, ui, result, exp);
    end
    n_chk++;
    if (a_is_zero !== (a == 32'h0)) begin
      n_bad++;
      $display("FAIL R11 a=%h: a_is_zero %0b expected %0b", a, a_is_zero, a == 32'h0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: done 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle inputs: all-zero result, zero flag set (R11, R8)
    check("R11", 4'd0, 32'h0, 32'h0, 16'h0, 1'b0);
    // R8: every code once
    for (int k = 0; k < 16; k++)
      check("R8", 4'(k), 32'h8765_4321, 32'h0000_0013, 16'h0, 1'b0);
    // R1 / R2 wraparound
    check("R1", 4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, 1'b0);
    check("R2", 4'd1, 32'h0000_0000, 32'h0000_0001, 16'h0, 1'b0);
    check("R2", 4'd1, 32'h8000_0000, 32'h0000_0001, 16'h0, 1'b0);
    // R10 load constant, negative and positive
    check("R10", 4'd0, 32'h0, 32'h1234_5678, 16'h8000, 1'b1);
    check("R10", 4'd0, 32'h0, 32'h1234_5678, 16'h7FFF, 1'b1);
    // R4 / R5 extension
    check("R4", 4'd1, 32'h0000_0010, 32'h0, 16'hFFFF, 1'b1);
    check("R5", 4'd3, 32'h0000_0000, 32'h0, 16'hFFFF, 1'b1);
    check("R5", 4'd2, 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1);
    // R6 shift amount from low five bits, fills
    check("R6", 4'd5, 32'h0000_0001, 32'h0000_0021, 16'h0, 1'b0);
    check("R6", 4'd7, 32'h8000_0000, 32'h0000_001F, 16'h0, 1'b0);
    check("R6", 4'd6, 32'h8000_0000, 32'h0000_001F, 16'h0, 1'b0);
    // R7 signed boundaries
    check("R7", 4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0);
    check("R7", 4'd9, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0);
    check("R7", 4'd10, 32'h1234, 32'h1234, 16'h0, 1'b0);
    check("R7", 4'd11, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0);
    check("R7", 4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0);
    check("R7", 4'd13, 32'h5, 32'h5, 16'h0, 1'b0);
    // compare with immediate: widening and relation in the same evaluation
    check("R4", 4'd8, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 1'b1);
    check("R4", 4'd9, 32'h0000_0001, 32'h0, 16'h8000, 1'b1);
    check("R4", 4'd12, 32'hFFFF_8000, 32'h0, 16'h8000, 1'b1);
    // R9 unused codes
    check("R9", 4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1);
    check("R9", 4'd15, 32'h1, 32'h1, 16'h1, 1'b0);
    // R12 immediate ignored in register form
    drive(4'd0, 32'h1111_2222, 32'h0303_0404, 16'h0000, 1'b0);
    r0 = result;
    check("R12", 4'd0, 32'h1111_2222, 32'h0303_0404, 16'hBEEF, 1'b0);
    n_chk++;
    if (result !== r0) begin
      n_bad++;
      $display("FAIL R12: result %h expected %h", result, r0);
    end
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      logic [15:0] im;
      logic        ui;
      op = 4'($urandom_range(0, 15));
      a  = $urandom;
      b  = $urandom;
      im = 16'($urandom);
      ui = 1'($urandom);
      case ($urandom_range(0, 7))
        0: a = 32'h0;
        1: b = a;
        2: a = {{16{im[15]}}, im};
        3: b = 32'($urandom_range(0, 40));
        default: ;
      endcase
      check(tag_of(op, ui), op, a, b, im, ui);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule